// File: doc/BRIEF.md
# Dual Event Performance Counter Unit

This unit sits next to a processor pipeline and counts hardware events on two independent 32-bit counters. Each cycle the pipeline presents sixteen event strobes per counter, the current privilege mode and an exception-level flag. A shared control word picks one strobe per counter and says in which privilege situations counting is allowed. A counter advances by one on each cycle where its chosen strobe is high and the current situation is enabled.

Software sees two registers through a small write port and a combinational read port. The first is the control word. The second is a 64-bit register that holds both counters side by side, and a single write loads both at once. A counter signals overflow through its most significant bit rather than through a carry. To sample every N events, software therefore preloads 0x80000000 minus N. The interrupt output is shared with other sources, so the interrupt enable is readable back. This lets a handler check whether this unit could have raised the request.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset the control register reads zero, the counter register reads zero and `irq` is low.
- R2: Counter 0 counts the strobe of `evtStrobe0` indexed by control bits 8:5. Counter 1 counts the strobe of `evtStrobe1` indexed by control bits 12:9. Each counter adds at most one per cycle.
- R3: With `excLevel` low, counting is allowed in kernel mode (`privMode`=0) when control bit 1 is set, in supervisor mode (`privMode`=1) when bit 2 is set, and in user mode (`privMode`=2) when bit 3 is set. `privMode`=3 never counts.
- R4: With `excLevel` high, counting is allowed exactly when control bit 0 is set, whatever the value of `privMode`.
- R5: With `regSel`=1, a write loads counter 0 from data bits 31:0 and counter 1 from bits 63:32 in the same cycle. A read returns the counters in the same layout.
- R6: With `regSel`=0, the control register holds bits 12:0 of the write data. Bits 31:13 and read bits 63:32 read as zero, and writes to them have no effect.
- R7: `irq` is high exactly when control bit 4 is set and bit 31 of either counter is set. Control bit 4 reads back as written. `irq` falls once software rewrites the counters below 0x80000000.
- R8: A counter keeps counting after bit 31 sets, and it wraps from 0xFFFFFFFF to 0.
- R9: A counter-register write in the same cycle as an enabled event loads the written value, and that cycle's event is lost.
- R10: With the control register zero, no event changes either counter and `irq` stays low, even when a counter has bit 31 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtStrobe0 | input | 16 | Per-cycle event strobes for counter 0 |
| evtStrobe1 | input | 16 | Per-cycle event strobes for counter 1 |
| privMode | input | 2 | Current mode: 0 kernel, 1 supervisor, 2 user, 3 none |
| excLevel | input | 1 | Processor is at exception level |
| regWe | input | 1 | Register write strobe |
| regSel | input | 1 | Register select: 0 control, 1 counters |
| regWdata | input | 64 | Write data |
| regRdata | output | 64 | Read data of the selected register |
| irq | output | 1 | Overflow interrupt request |

## Verification
The hardest condition to reach is an overflow with a long count period, because bit 31 normally needs about two billion events. The bench avoids the wait by preloading counters a few steps below 0x80000000 and below 0xFFFFFFFF. It then steps single events across both edges. The combinations of mode, exception flag and enable bits are swept in full, with the expected count worked out arithmetically for each one. Event selection is checked with nested strobe patterns, so that each select value gives its own distinct count.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int CNT_W    = 32;
  localparam int NUM_CNT  = 2;
  localparam int SEL_W    = 4;
  localparam int NUM_EVT  = 1 << SEL_W;
  localparam int CTRL_W   = 32;
  localparam int CNTREG_W = CNT_W * NUM_CNT;

  // control word layout (software-visible)
  localparam int EXL_BIT   = 0;
  localparam int KERN_BIT  = 1;
  localparam int SUPV_BIT  = 2;
  localparam int USER_BIT  = 3;
  localparam int IE_BIT    = 4;
  localparam int SEL_LSB   = 5;
  localparam int CTRL_USED = SEL_LSB + NUM_CNT * SEL_W;

  typedef enum logic [1:0] {
    MODE_KERN = 2'd0,
    MODE_SUPV = 2'd1,
    MODE_USER = 2'd2,
    MODE_NONE = 2'd3
  } privMode_t;

  typedef struct packed {
    logic               loadCnt;
    logic [NUM_CNT-1:0] inc;
  } cntStrobe_t;
endpackage

// File: rtl/pmu_control.sv
module pmu_control
  import pmu_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             regWe,
  input  logic                             regSel,
  input  logic [CTRL_W-1:0]                regWdata,
  input  logic [NUM_CNT-1:0][NUM_EVT-1:0]  evtVec,
  input  logic [1:0]                       privMode,
  input  logic                             excLevel,
  output logic [CTRL_W-1:0]                ctrlQ,
  output cntStrobe_t                       strobes
);
  localparam logic [CTRL_W-1:0] CTRL_MASK = CTRL_W'((64'd1 << CTRL_USED) - 64'd1);

  logic               modeOk;
  logic [NUM_CNT-1:0] evtHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (regWe && !regSel) begin
      ctrlQ <= regWdata & CTRL_MASK;
    end
  end

  always_comb begin
    if (excLevel) begin
      modeOk = ctrlQ[EXL_BIT];
    end else begin
      case (privMode_t'(privMode))
        MODE_KERN: modeOk = ctrlQ[KERN_BIT];
        MODE_SUPV: modeOk = ctrlQ[SUPV_BIT];
        MODE_USER: modeOk = ctrlQ[USER_BIT];
        default:   modeOk = 1'b0;
      endcase
    end
  end

  for (genvar c = 0; c < NUM_CNT; c++) begin : g_sel
    logic [SEL_W-1:0] evtSel;
    assign evtSel    = ctrlQ[SEL_LSB + c*SEL_W +: SEL_W];
    assign evtHit[c] = evtVec[c][evtSel];
  end

  assign strobes.loadCnt = regWe && regSel;
  assign strobes.inc     = evtHit & {NUM_CNT{modeOk}};
endmodule

// File: rtl/pmu_datapath.sv
module pmu_datapath
  import pmu_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  cntStrobe_t          strobes,
  input  logic [CNTREG_W-1:0] loadData,
  output logic [CNTREG_W-1:0] cntQ,
  output logic                anyMsb
);
  logic [NUM_CNT-1:0] msbVec;

  for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt <= '0;
      end else if (strobes.loadCnt) begin
        cnt <= loadData[c*CNT_W +: CNT_W];
      end else if (strobes.inc[c]) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
    assign cntQ[c*CNT_W +: CNT_W] = cnt;
    assign msbVec[c]              = cnt[CNT_W-1];
  end

  assign anyMsb = |msbVec;
endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
  import pmu_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_EVT-1:0]  evtStrobe0,
  input  logic [NUM_EVT-1:0]  evtStrobe1,
  input  logic [1:0]          privMode,
  input  logic                excLevel,
  input  logic                regWe,
  input  logic                regSel,
  input  logic [CNTREG_W-1:0] regWdata,
  output logic [CNTREG_W-1:0] regRdata,
  output logic                irq
);
  logic [CTRL_W-1:0]               ctrlQ;
  logic [CNTREG_W-1:0]             cntQ;
  logic                            anyMsb;
  cntStrobe_t                      strobes;
  logic [NUM_CNT-1:0][NUM_EVT-1:0] evtVec;

  assign evtVec[0] = evtStrobe0;
  assign evtVec[1] = evtStrobe1;

  pmu_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regSel   (regSel),
    .regWdata (regWdata[CTRL_W-1:0]),
    .evtVec   (evtVec),
    .privMode (privMode),
    .excLevel (excLevel),
    .ctrlQ    (ctrlQ),
    .strobes  (strobes)
  );

  pmu_datapath u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .loadData (regWdata),
    .cntQ     (cntQ),
    .anyMsb   (anyMsb)
  );

  assign irq      = ctrlQ[IE_BIT] && anyMsb;
  assign regRdata = regSel ? cntQ : CNTREG_W'(ctrlQ);
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker
  import pmu_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                regWe,
  input logic                regSel,
  input logic [CNTREG_W-1:0] regWdata,
  input logic [CTRL_W-1:0]   ctrlQ,
  input logic [CNTREG_W-1:0] cntQ,
  input logic                irq
);
  // R9
  load_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regSel) |=> (cntQ == $past(regWdata)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[USER_BIT:EXL_BIT] == '0 && !regWe) |=> $stable(cntQ));

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ[IE_BIT] |-> !irq);

  // R2
  lo_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regWe |=> (cntQ[CNT_W-1:0] == $past(cntQ[CNT_W-1:0]) ||
                cntQ[CNT_W-1:0] == $past(cntQ[CNT_W-1:0]) + CNT_W'(1)));

  // R2
  hi_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regWe |=> (cntQ[CNTREG_W-1:CNT_W] == $past(cntQ[CNTREG_W-1:CNT_W]) ||
                cntQ[CNTREG_W-1:CNT_W] == $past(cntQ[CNTREG_W-1:CNT_W]) + CNT_W'(1)));

  // R6
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlQ[CTRL_W-1:CTRL_USED] == '0);
endmodule

bind perf_counter_unit pmu_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWe    (regWe),
  .regSel   (regSel),
  .regWdata (regWdata),
  .ctrlQ    (ctrlQ),
  .cntQ     (cntQ),
  .irq      (irq)
);

// File: tb/perf_counter_unit_bench.sv
`timescale 1ns/1ps
module perf_counter_unit_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] evtStrobe0, evtStrobe1;
  logic [1:0]  privMode;
  logic        excLevel;
  logic        regWe, regSel;
  logic [63:0] regWdata, regRdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  perf_counter_unit u_perf_counter_unit (
    .clk(clk), .rstN(rstN), .evtStrobe0(evtStrobe0), .evtStrobe1(evtStrobe1),
    .privMode(privMode), .excLevel(excLevel), .regWe(regWe), .regSel(regSel),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [63:0] d);
    @(negedge clk);
    regWe = 1'b1; regSel = sel; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [63:0] d);
    regSel = sel;
    #1;
    d = regRdata;
  endtask

  task automatic pulse(input logic [15:0] a, input logic [15:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      evtStrobe0 = a; evtStrobe1 = b;
    end
    @(negedge clk);
    evtStrobe0 = '0; evtStrobe1 = '0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    rstN = 1'b0; evtStrobe0 = '0; evtStrobe1 = '0; privMode = 2'd0;
    excLevel = 1'b0; regWe = 1'b0; regSel = 1'b0; regWdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, d); chk("R1 ctrl", d, 64'h0);
    rd(1'b1, d); chk("R1 cnt", d, 64'h0);
    chk("R1 irq", {63'h0, irq}, 64'h0);

    // R5 packed load and readback
    wr(1'b1, 64'h1234_5678_9ABC_DEF0);
    rd(1'b1, d); chk("R5 readback", d, 64'h1234_5678_9ABC_DEF0);

    // R10 control zero: no counting, no irq although counter 0 has bit 31
    wr(1'b1, 64'h8000_0001_FFFF_FFF0);
    privMode = 2'd2;
    pulse(16'hFFFF, 16'hFFFF, 10);
    rd(1'b1, d); chk("R10 frozen", d, 64'h8000_0001_FFFF_FFF0);
    chk("R10 irq", {63'h0, irq}, 64'h0);

    // R6 reserved bits
    wr(1'b1, 64'h0);
    wr(1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(1'b0, d); chk("R6 mask", d, 64'h0000_0000_0000_1FFF);
    wr(1'b0, 64'h0);

    // R2 select sweep: counter 0 sees bits 0..k, counter 1 sees bits k..15
    privMode = 2'd0;
    for (int s = 0; s < 16; s++) begin
      int s1;
      s1 = 15 - s;
      wr(1'b1, 64'h0);
      wr(1'b0, 64'(32'h2 | (s << 5) | (s1 << 9)));
      for (int k = 0; k < 16; k++) begin
        @(negedge clk);
        evtStrobe0 = 16'((32'd1 << (k + 1)) - 1);
        evtStrobe1 = 16'(16'hFFFF << k);
      end
      @(negedge clk);
      evtStrobe0 = '0; evtStrobe1 = '0;
      rd(1'b1, d);
      chk("R2 cnt0", {32'h0, d[31:0]}, 64'(16 - s));
      chk("R2 cnt1", {32'h0, d[63:32]}, 64'(s1 + 1));
    end

    // R3 / R4 exhaustive mode sweep
    for (int en = 0; en < 16; en++) begin
      for (int m = 0; m < 4; m++) begin
        for (int x = 0; x < 2; x++) begin
          bit ok;
          int e;
          if (x == 1) ok = en[0];
          else ok = (m < 3) && en[m + 1];
          e = ok ? 5 : 0;
          wr(1'b1, 64'h0);
          wr(1'b0, 64'(en | (3 << 5) | (7 << 9)));
          privMode = 2'(m); excLevel = 1'(x);
          pulse(16'h0008, 16'h0080, 5);
          rd(1'b1, d);
          if (x == 1) chk("R4 exl cnt0", {32'h0, d[31:0]}, 64'(e));
          else chk("R3 mode cnt0", {32'h0, d[31:0]}, 64'(e));
          if (x == 1) chk("R4 exl cnt1", {32'h0, d[63:32]}, 64'(e));
          else chk("R3 mode cnt1", {32'h0, d[63:32]}, 64'(e));
        end
      end
    end
    excLevel = 1'b0; privMode = 2'd2;

    // R7 overflow interrupt
    wr(1'b0, 64'h0000_0000_0000_0458); // IE, user, sel0=2, sel1=2
    rd(1'b0, d); chk("R7 ie readback", {63'h0, d[4]}, 64'h1);
    wr(1'b1, 64'h0000_0000_7FFF_FFFD);
    pulse(16'h0004, 16'h0000, 2);
    chk("R7 irq before", {63'h0, irq}, 64'h0);
    pulse(16'h0004, 16'h0000, 1);
    chk("R7 irq cnt0", {63'h0, irq}, 64'h1);
    wr(1'b1, 64'h7FFF_FFFF_0000_0000);
    chk("R7 irq cleared", {63'h0, irq}, 64'h0);
    pulse(16'h0000, 16'h0004, 1);
    chk("R7 irq cnt1", {63'h0, irq}, 64'h1);
    wr(1'b0, 64'h0000_0000_0000_0448);
    rd(1'b0, d); chk("R7 ie off readback", {63'h0, d[4]}, 64'h0);
    chk("R7 irq gated", {63'h0, irq}, 64'h0);
    pulse(16'h0004, 16'h0004, 3);
    chk("R7 irq still gated", {63'h0, irq}, 64'h0);
    wr(1'b0, 64'h0000_0000_0000_0458);
    chk("R7 irq reenabled", {63'h0, irq}, 64'h1);
    wr(1'b1, 64'h0);
    chk("R7 irq after rewrite", {63'h0, irq}, 64'h0);

    // R8 wrap and continue past bit 31
    wr(1'b1, 64'hFFFF_FFFF_7FFF_FFFF);
    pulse(16'h0004, 16'h0004, 1);
    rd(1'b1, d); chk("R8 wrap", d, 64'h0000_0000_8000_0000);
    pulse(16'h0004, 16'h0004, 2);
    rd(1'b1, d); chk("R8 continue", d, 64'h0000_0002_8000_0002);

    // R9 write beats increment in the same cycle
    @(negedge clk);
    evtStrobe0 = 16'h0004; evtStrobe1 = 16'h0004;
    regWe = 1'b1; regSel = 1'b1; regWdata = 64'h0000_0005_0000_0009;
    @(negedge clk);
    regWe = 1'b0; evtStrobe0 = '0; evtStrobe1 = '0;
    rd(1'b1, d); chk("R9 priority", d, 64'h0000_0005_0000_0009);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule